// File: doc/BRIEF.md
# Encoded SPI Clock Prescaler

This block derives the serial bit rate for an SPI shift engine from the parent clock. Each direction has its own 16-bit setting register, one for transmit and one for receive. Software normally writes both with the same code. The code selects one of eleven power-of-two ratios between 1 and 1024. The low byte chooses a base ratio, and an upper byte of 0x1F adds a further divide-by-32 stage. Code 0x0007 is a bypass that runs at the full parent rate.

While the shared enable is high, each channel produces a one-cycle `tick` at the selected rate. It also produces an SCK level with 50% duty: low for the first half of each period and high for the second half. While the enable is low, each counter is held at zero and both outputs stay at their idle level. A new code is applied only when the counter wraps or while the enable is low, so a period that is already running is never shortened.

Top module: `sck_prescaler`

## Requirements
- R1: Code 0x0007 selects ratio 1. While enabled, `tick` is high in every cycle and `sck` stays low.
- R2: When bits 15:8 are 0x00, low-byte values 0, 1, 2, 3 and 4 select ratios 2, 4, 8, 16 and 32.
- R3: When bits 15:8 are 0x1F, low-byte values 0, 1, 2, 3 and 4 select ratios 64, 128, 256, 512 and 1024.
- R4: Every code outside R1 to R3 selects ratio 1024.
- R5: After reset, both setting registers hold 0x1F04, which is ratio 1024, and `tick` and `sck` are low.
- R6: For a ratio R, the first tick comes in the R-th cycle after the enable rises. Later ticks follow every R cycles.
- R7: For R of 2 or more, `sck` is low for the first R/2 cycles of each period and high for the last R/2. It falls in the cycle after a tick.
- R8: While `clk_en` is low, `tick` and `sck` are low and the counter is held at zero. Raising the enable again restarts the count from zero.
- R9: A code written while the channel is running takes effect only after the current period ends with its tick.
- R10: A write with `cfg_sel`=0 loads the transmit register, which drives bit 0 of the outputs. A write with `cfg_sel`=1 loads the receive register, which drives bit 1. A write to one channel leaves the other unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parent clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_en | input | 1 | Serial clock enable shared by both channels |
| cfg_we | input | 1 | Write strobe for a setting register |
| cfg_sel | input | 1 | Register select: 0 transmit, 1 receive |
| cfg_wdata | input | 16 | Divider code to write |
| tick | output | 2 | One-cycle rate pulse per channel (bit 0 transmit, bit 1 receive) |
| sck | output | 2 | 50% duty serial clock level per channel |

## Verification
The main stimulus is a sweep over every supported code and several unsupported ones:
- Supported codes: measuring the first and second tick positions and the SCK high time tells apart every decoded ratio, including the bypass.
- Unsupported codes: codes whose upper byte is neither 0x00 nor 0x1F, and codes whose low byte is out of range, show whether they fall back to 1024 instead of aliasing onto a valid ratio.

Further directed patterns cover the following:
- Reset default: enabling with no write shows the ratio-1024 reset value.
- Enable dropped mid-period: shows the outputs are silent and the count restarts from zero.
- Write to one channel while running: separates a change applied at once from one deferred to the wrap, and shows the channels are independent.

// File: rtl/sck_prescaler.sv
module sck_prescaler #(
  parameter int CODE_W = 16,
  parameter int MAX_LOG = 10,
  parameter logic [CODE_W-1:0] RESET_CODE = 16'h1F04
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clk_en,
  input  logic              cfg_we,
  input  logic              cfg_sel,
  input  logic [CODE_W-1:0] cfg_wdata,
  output logic [1:0]        tick,
  output logic [1:0]        sck
);

  localparam int LOG_W = $clog2(MAX_LOG + 1);
  localparam int HI_W  = CODE_W - 8;
  localparam logic [CODE_W-1:0] BYPASS_CODE = CODE_W'(16'h0007);
  localparam logic [HI_W-1:0]   EXT_STAGE   = HI_W'(8'h1F);

  function automatic logic [LOG_W-1:0] decode(input logic [CODE_W-1:0] code);
    logic [HI_W-1:0] hi;
    logic [7:0]      lo;
    hi = code[CODE_W-1:8];
    lo = code[7:0];
    if (code == BYPASS_CODE)                 return '0;
    if (hi == '0 && lo <= 8'd4)             return LOG_W'(lo[3:0]) + LOG_W'(1);
    if (hi == EXT_STAGE && lo <= 8'd4)      return LOG_W'(lo[3:0]) + LOG_W'(6);
    return LOG_W'(MAX_LOG);
  endfunction

  logic [1:0] bypass;

  for (genvar ch = 0; ch < 2; ch++) begin : g_chan
    logic [CODE_W-1:0]  code_q;
    logic [LOG_W-1:0]   shift_q;
    logic [MAX_LOG-1:0] cnt_q;
    logic [MAX_LOG:0]   span;
    logic [MAX_LOG-1:0] last;
    logic [MAX_LOG-1:0] half;
    logic               wrap;

    assign span = (MAX_LOG+1)'(1) << shift_q;
    assign last = span[MAX_LOG-1:0] - MAX_LOG'(1);
    assign half = span[MAX_LOG:1];
    assign wrap = clk_en && (cnt_q == last);

    assign tick[ch]   = wrap;
    assign sck[ch]    = clk_en && (shift_q != '0) && (cnt_q >= half);
    assign bypass[ch] = (shift_q == '0);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        code_q  <= RESET_CODE;
        shift_q <= decode(RESET_CODE);
        cnt_q   <= '0;
      end else begin
        if (cfg_we && cfg_sel == 1'(ch))
          code_q <= cfg_wdata;
        if (!clk_en || wrap) begin
          shift_q <= decode(code_q);
          cnt_q   <= '0;
        end else begin
          cnt_q <= cnt_q + MAX_LOG'(1);
        end
      end
    end
  end

endmodule

// File: rtl/sck_prescaler_chk.sv
module sck_prescaler_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       clk_en,
  input logic [1:0] tick,
  input logic [1:0] sck,
  input logic [1:0] bypass
);

  for (genvar c = 0; c < 2; c++) begin : g_chk
    // R8
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !clk_en |-> (!tick[c] && !sck[c]));

    // R1
    bypass_sck_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clk_en && bypass[c]) |-> !sck[c]);

    // R6
    back_to_back_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clk_en && $past(clk_en) && tick[c] && $past(tick[c])) |-> bypass[c]);

    // R7
    sck_fall_at_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clk_en && $past(clk_en) && $fell(sck[c])) |-> $past(tick[c]));
  end

endmodule

bind sck_prescaler sck_prescaler_chk i_chk (
  .clk(clk), .rst_n(rst_n), .clk_en(clk_en),
  .tick(tick), .sck(sck), .bypass(bypass)
);

// File: tb/test_sck_prescaler.sv
`timescale 1ns/1ps
module test_sck_prescaler;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clk_en = 1'b0;
  logic        cfg_we = 1'b0;
  logic        cfg_sel = 1'b0;
  logic [15:0] cfg_wdata = '0;
  logic [1:0]  tick;
  logic [1:0]  sck;

  always #2 clk = ~clk;

  sck_prescaler i_sck_prescaler (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .cfg_we(cfg_we),
    .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .tick(tick), .sck(sck)
  );

  localparam int NV = 16;
  localparam logic [15:0] CODES [NV] = '{
    16'h0007, 16'h0000, 16'h0001, 16'h0002, 16'h0003, 16'h0004,
    16'h1F00, 16'h1F01, 16'h1F02, 16'h1F03, 16'h1F04,
    16'h0005, 16'h1F05, 16'h0107, 16'h2000, 16'h0006};
  localparam int RATIOS [NV] = '{
    1, 2, 4, 8, 16, 32, 64, 128, 256, 512, 1024,
    1024, 1024, 1024, 1024, 1024};

  int nchk = 0;
  int nbad = 0;
  int first_t [2];
  int second_t [2];
  int high_t [2];
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    nchk++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wr(input bit sel, input logic [15:0] code);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = code;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic measure(input int ncyc, input int r);
    for (int c = 0; c < 2; c++) begin
      first_t[c] = 0; second_t[c] = 0; high_t[c] = 0;
    end
    for (int i = 1; i <= ncyc; i++) begin
      #1;
      for (int c = 0; c < 2; c++) begin
        if (tick[c]) begin
          if (first_t[c] == 0) first_t[c] = i;
          else if (second_t[c] == 0) second_t[c] = i;
        end
        if (i <= r && sck[c]) high_t[c]++;
      end
      @(negedge clk);
    end
  endtask

  task automatic check_rate(input string req, input int r);
    for (int c = 0; c < 2; c++) begin
      chk(first_t[c] == r, req, c == 0 ? "tx first tick" : "rx first tick", first_t[c], r);
      chk(second_t[c] == 2*r, req, c == 0 ? "tx second tick" : "rx second tick", second_t[c], 2*r);
      chk(high_t[c] == r/2, req, c == 0 ? "tx sck high" : "rx sck high", high_t[c], r/2);
    end
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      nchk++; nbad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", nchk, nbad);
      $finish;
    end
  end

  initial begin
    logic [7:0] txm, rxm;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R5 reset state
    chk(tick == 2'b00 && sck == 2'b00, "R5", "outputs after reset", {tick, sck}, 0);
    @(negedge clk);
    // R5 R6 default ratio 1024
    clk_en = 1'b1;
    measure(2048, 1024);
    check_rate("R5", 1024);
    clk_en = 1'b0;

    // R1 R2 R3 R4 R6 R7 code sweep
    for (int v = 0; v < NV; v++) begin
      clk_en = 1'b0;
      wr(1'b0, CODES[v]);
      wr(1'b1, CODES[v]);
      @(negedge clk);
      clk_en = 1'b1;
      measure(2 * RATIOS[v], RATIOS[v]);
      check_rate(v == 0 ? "R1" : v <= 5 ? "R2" : v <= 10 ? "R3" : "R4", RATIOS[v]);
      clk_en = 1'b0;
    end

    // R8 disable mid-period then restart
    @(negedge clk);
    wr(1'b0, 16'h0001);
    wr(1'b1, 16'h0001);
    @(negedge clk);
    clk_en = 1'b1;
    repeat (3) @(negedge clk);
    clk_en = 1'b0;
    for (int i = 0; i < 5; i++) begin
      #1;
      chk(tick == 2'b00 && sck == 2'b00, "R8", "outputs while disabled", {tick, sck}, 0);
      @(negedge clk);
    end
    clk_en = 1'b1;
    measure(8, 4);
    check_rate("R8", 4);
    clk_en = 1'b0;

    // R9 R10 change tx code while running
    @(negedge clk);
    wr(1'b0, 16'h0001);
    wr(1'b1, 16'h0001);
    @(negedge clk);
    clk_en = 1'b1;
    txm = '0; rxm = '0;
    for (int i = 1; i <= 8; i++) begin
      #1;
      txm[i-1] = tick[0];
      rxm[i-1] = tick[1];
      @(negedge clk);
      if (i == 1) begin cfg_we = 1'b1; cfg_sel = 1'b0; cfg_wdata = 16'h0000; end
      if (i == 2) cfg_we = 1'b0;
    end
    chk(txm == 8'hA8, "R9", "tx tick pattern after mid-period write", txm, 8'hA8);
    chk(rxm == 8'h88, "R10", "rx tick pattern unaffected by tx write", rxm, 8'h88);
    clk_en = 1'b0;

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end

endmodule